// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a bank of general-purpose pins that is controlled through memory-mapped registers. For each pin, software picks the direction and the value to drive. Software can also read the pad level after it has been synchronised. Each pin has an interrupt detector. The detector works in level mode or in single-edge mode, with a polarity bit that selects which level or edge counts as a trigger.

A trigger feeds two paths, and each path has its own enable bit:
- One path latches a status flag, which software clears by writing one to it.
- The other path asserts the pin's interrupt.

Because the two enables are separate, an interrupt can fire without any status being recorded. A per-pin routing code decides whether the interrupt reaches the application processor. The single summary output is the OR of every pin whose interrupt is active and whose routing code selects that processor.

The bus is a plain word-addressed register port. Writes take effect on the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every pin is an input (`pad_oe` low) with `pad_out` low. The configuration, in/out, interrupt configuration and status registers read 0, every routing register reads 7, and `summary_irq` is low.
- R2: Pin i's registers sit at 0x1000 + 16·i. The word at offset 0x0 is configuration, 0x4 is in/out, 0x8 is interrupt configuration and 0xC is status. The routing word for pin i is at 0x400 + 4·i. Reads of any other address return 0, and writes to any other address change nothing.
- R3: Configuration bit 9 drives `pad_oe` of the pin. In/out bit 1 is stored and drives `pad_out`. In/out bit 0 is read-only and returns the pad input after a two-flop synchroniser; a write to bit 0 has no effect.
- R4: Interrupt configuration bits: bit 0 is the interrupt enable, bit 1 is the polarity (1 = high level or rising edge), bit 2 is the mode (1 = edge, 0 = level) and bit 3 is the status-latch enable.
- R5: In level mode the pin's interrupt is active whenever the synchronised input equals the polarity. This stays true after the status is cleared, and the interrupt drops once the input leaves that level.
- R6: In edge mode only the transition toward the polarity level triggers. The opposite edge neither sets status nor asserts the interrupt.
- R7: An edge-mode interrupt stays asserted after the input returns, until software writes 1 to status bit 0.
- R8: With bit 3 clear, a trigger never sets status bit 0, even when the interrupt is asserted.
- R9: With bit 0 clear, the interrupt is never asserted, even though status bit 0 still latches the trigger.
- R10: Writing 1 to status bit 0 clears the latched status. Writing 0 to it leaves the status unchanged.
- R11: `summary_irq` is high exactly while some pin with routing code 4 has an active interrupt. Code 7, or any code other than 4, keeps the pin off the summary line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 13 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Output value per pin |
| pad_oe | output | NPINS | Output enable per pin |
| summary_irq | output | 1 | OR of interrupts routed to the application processor |

## Verification
The case that is hardest to reach is a trigger on which the two enables disagree. In that case the interrupt line and the status flag must move in opposite directions. The stimulus holds a pad high in level mode. It programs interrupt-enable-only and observes the summary line high with status reading zero. It then rewrites the configuration to status-only and observes the reverse. A second hard case is the edge-mode hold. A rising edge is followed by the pad falling again, and the bench checks that the summary line stays up until the status write, and that a later falling edge does not raise it again.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BUS_AW = 13;
  localparam int BUS_DW = 32;
  localparam int ROUTE_W = 3;
  localparam logic [ROUTE_W-1:0] ROUTE_APP  = 3'd4;
  localparam logic [ROUTE_W-1:0] ROUTE_NONE = 3'd7;
  localparam int OE_BIT = 9;

  typedef enum logic [2:0] {
    RK_CFG   = 3'd0,
    RK_IO    = 3'd1,
    RK_ICFG  = 3'd2,
    RK_STAT  = 3'd3,
    RK_ROUTE = 3'd4
  } reg_kind_t;

  typedef struct packed {
    logic lat_en;
    logic edge_md;
    logic pol;
    logic int_en;
  } icfg_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_unit.sv
module gpio_pin_unit
  import gpio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pad_in,
  input  logic              sel,
  input  logic              we,
  input  reg_kind_t         kind,
  input  logic [BUS_DW-1:0] wdata,
  output logic [BUS_DW-1:0] rdata,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              irq_raw,
  output logic              irq_app
);
  logic               s_in;
  logic               prev_q;
  logic               oe_q, oe_d;
  logic               out_q, out_d;
  icfg_t              icfg_q, icfg_d;
  logic               stat_q, stat_d;
  logic               pend_q, pend_d;
  logic [ROUTE_W-1:0] route_q, route_d;

  logic cfg_w, io_w, icfg_w, stat_w, route_w, stat_clr;
  logic level_hit, edge_hit, trig;

  gpio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(s_in)
  );

  always_comb begin
    cfg_w    = sel && we && (kind == RK_CFG);
    io_w     = sel && we && (kind == RK_IO);
    icfg_w   = sel && we && (kind == RK_ICFG);
    stat_w   = sel && we && (kind == RK_STAT);
    route_w  = sel && we && (kind == RK_ROUTE);
    stat_clr = stat_w && wdata[0];

    level_hit = (s_in == icfg_q.pol);
    edge_hit  = icfg_q.pol ? (s_in && !prev_q) : (!s_in && prev_q);
    trig      = icfg_q.edge_md ? edge_hit : level_hit;

    oe_d    = cfg_w   ? wdata[OE_BIT]         : oe_q;
    out_d   = io_w    ? wdata[1]              : out_q;
    icfg_d  = icfg_w  ? icfg_t'(wdata[3:0])   : icfg_q;
    route_d = route_w ? wdata[ROUTE_W-1:0]    : route_q;

    if (icfg_q.lat_en && trig) stat_d = 1'b1;
    else if (stat_clr)         stat_d = 1'b0;
    else                       stat_d = stat_q;

    if (icfg_q.edge_md && icfg_q.int_en && edge_hit)   pend_d = 1'b1;
    else if (stat_clr || !icfg_q.edge_md || !icfg_q.int_en) pend_d = 1'b0;
    else                                                pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      oe_q    <= 1'b0;
      out_q   <= 1'b0;
      icfg_q  <= '0;
      stat_q  <= 1'b0;
      pend_q  <= 1'b0;
      route_q <= ROUTE_NONE;
    end else begin
      prev_q  <= s_in;
      oe_q    <= oe_d;
      out_q   <= out_d;
      icfg_q  <= icfg_d;
      stat_q  <= stat_d;
      pend_q  <= pend_d;
      route_q <= route_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      unique case (kind)
        RK_CFG:   rdata[OE_BIT]      = oe_q;
        RK_IO:    rdata[1:0]         = {out_q, s_in};
        RK_ICFG:  rdata[3:0]         = icfg_q;
        RK_STAT:  rdata[0]           = stat_q;
        RK_ROUTE: rdata[ROUTE_W-1:0] = route_q;
        default:  rdata              = '0;
      endcase
    end
  end

  assign pad_oe  = oe_q;
  assign pad_out = out_q;
  assign irq_raw = icfg_q.int_en && (icfg_q.edge_md ? pend_q : level_hit);
  assign irq_app = irq_raw && (route_q == ROUTE_APP);

  // R8
  lat_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !icfg_q.lat_en |=> !$rose(stat_q));

  // R9
  int_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !icfg_q.int_en |-> !irq_raw);

  // R7
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_raw && icfg_q.edge_md && !stat_clr && !icfg_w) |=> irq_raw);

  // R3
  oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_w |=> (pad_oe == $past(wdata[OE_BIT])));

  // R11
  route_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q != ROUTE_APP) |-> !irq_app);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              summary_irq
);
  localparam int IDX_W = 8;

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic             pin_area, route_area;
  logic [IDX_W-1:0] idx_pin, idx_route;
  reg_kind_t        kind;

  always_comb begin
    pin_area   = bus_addr[12];
    route_area = (bus_addr[12:10] == 3'b001);
    idx_pin    = bus_addr[11:4];
    idx_route  = bus_addr[9:2];
    kind       = route_area ? RK_ROUTE : reg_kind_t'({1'b0, bus_addr[3:2]});
  end

  logic [NPINS-1:0]  sel;
  logic [NPINS-1:0]  irq_raw;
  logic [NPINS-1:0]  irq_app;
  logic [BUS_DW-1:0] pin_rdata [NPINS];

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign sel[i] = (pin_area && (idx_pin == IDX_W'(i))) ||
                    (route_area && (idx_route == IDX_W'(i)));

    gpio_pin_unit #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk(clk), .rst_n(rst_n_s), .pad_in(pad_in[i]),
      .sel(sel[i]), .we(bus_we), .kind(kind), .wdata(bus_wdata),
      .rdata(pin_rdata[i]), .pad_out(pad_out[i]), .pad_oe(pad_oe[i]),
      .irq_raw(irq_raw[i]), .irq_app(irq_app[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NPINS; i++) bus_rdata = bus_rdata | pin_rdata[i];
  end

  assign summary_irq = |irq_app;

  // R11
  summary_src_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(|irq_raw) |-> !summary_irq);

  // R2
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(sel));
endmodule

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [12:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe;
  logic          summary_irq;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  gpio_irq_bank #(.NPINS(N)) u_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .summary_irq(summary_irq)
  );

  function automatic logic [12:0] a_pin(int i, int off);
    return 13'(32'h1000 + 16 * i + off);
  endfunction
  function automatic logic [12:0] a_route(int i);
    return 13'(32'h400 + 4 * i);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [12:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(a_pin(0, 0), d);   chk("R1 cfg", d, 0);
    rd(a_pin(2, 8), d);   chk("R1 icfg", d, 0);
    rd(a_pin(1, 12), d);  chk("R1 status", d, 0);
    rd(a_route(3), d);    chk("R1 route", d, 7);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_out", pad_out, 0);
    chk("R1 summary", summary_irq, 0);
  endtask

  task automatic t_pads();
    logic [31:0] d;
    wr(a_pin(1, 0), 32'h200);
    #2 chk("R3 oe", pad_oe, 4'b0010);
    wr(a_pin(1, 4), 32'h2);
    #2 chk("R3 out", pad_out, 4'b0010);
    rd(a_pin(1, 4), d); chk("R3 io readback", d, 32'h2);
    pad_in[2] = 1'b1;
    settle();
    rd(a_pin(2, 4), d); chk("R3 pad sample", d, 32'h1);
    wr(a_pin(3, 4), 32'h1);
    rd(a_pin(3, 4), d); chk("R3 in bit read-only", d, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(a_route(0), 4);
    wr(a_pin(0, 8), 32'hB);
    rd(a_pin(0, 8), d); chk("R4 icfg readback", d, 32'hB);
    chk("R5 idle low", summary_irq, 0);
    pad_in[0] = 1'b1;
    settle();
    chk("R5 level irq", summary_irq, 1);
    rd(a_pin(0, 12), d); chk("R5 level status", d, 1);
    wr(a_pin(0, 12), 1);
    settle();
    chk("R5 irq after clear", summary_irq, 1);
    pad_in[0] = 1'b0;
    settle();
    chk("R5 irq drops", summary_irq, 0);
    rd(a_pin(0, 12), d); chk("R10 status latched", d, 1);
    wr(a_pin(0, 12), 0);
    rd(a_pin(0, 12), d); chk("R10 write 0 keeps", d, 1);
    wr(a_pin(0, 12), 1);
    rd(a_pin(0, 12), d); chk("R10 write 1 clears", d, 0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(a_route(1), 4);
    wr(a_pin(1, 8), 32'hF);
    settle();
    chk("R6 no edge yet", summary_irq, 0);
    pad_in[1] = 1'b1;
    settle();
    chk("R6 rising irq", summary_irq, 1);
    rd(a_pin(1, 12), d); chk("R6 rising status", d, 1);
    pad_in[1] = 1'b0;
    settle();
    chk("R7 held after input drop", summary_irq, 1);
    wr(a_pin(1, 12), 1);
    settle();
    chk("R7 released by clear", summary_irq, 0);
    rd(a_pin(1, 12), d); chk("R6 falling no status", d, 0);
    pad_in[1] = 1'b1;
    settle();
    wr(a_pin(1, 12), 1);
    pad_in[1] = 1'b0;
    settle();
    chk("R6 falling no irq", summary_irq, 0);
    rd(a_pin(1, 12), d); chk("R6 falling no status 2", d, 0);
  endtask

  task automatic t_gates();
    logic [31:0] d;
    wr(a_route(2), 4);
    wr(a_pin(2, 8), 32'h3);
    settle();
    chk("R8 irq fires", summary_irq, 1);
    rd(a_pin(2, 12), d); chk("R8 status stays clear", d, 0);
    wr(a_pin(2, 8), 32'hA);
    settle();
    chk("R9 irq blocked", summary_irq, 0);
    rd(a_pin(2, 12), d); chk("R9 status latches", d, 1);
    wr(a_pin(2, 8), 0);
    wr(a_pin(2, 12), 1);
  endtask

  task automatic t_route();
    logic [31:0] d;
    pad_in[3] = 1'b1;
    wr(a_pin(3, 8), 32'hB);
    settle();
    chk("R11 code 7 off", summary_irq, 0);
    wr(a_route(3), 4);
    #2 chk("R11 code 4 on", summary_irq, 1);
    wr(a_route(3), 5);
    #2 chk("R11 code 5 off", summary_irq, 0);
    rd(a_route(3), d); chk("R2 route readback", d, 5);
    rd(a_pin(N, 0), d); chk("R2 unmapped pin read", d, 0);
    rd(13'h0, d); chk("R2 unmapped low read", d, 0);
    wr(a_pin(N, 0), 32'h200);
    wr(13'h0, 32'h200);
    #2 chk("R2 unmapped write ignored", pad_oe, 4'b0010);
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_pads();
        t_level();
        t_edge();
        t_gates();
        t_route();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule